// File: doc/BRIEF.md
# Byte-Lane Bus Cycle Splitter

The block sits between a requester that thinks in byte addresses and an external data bus that is built from byte lanes and addressed only in whole aligned words. A request names a byte address, a transfer size of one, two or four bytes, a direction and write data. The block turns it into one bus cycle, or into two when the bytes run past the end of the current aligned word. Each cycle presents an aligned word address and active-low byte enables over a contiguous group of lanes. On writes each byte is placed on its own lane.

Each cycle is held on the bus until the external side answers with a ready strobe. On reads, the lanes that were enabled are collected across both cycles and returned right-justified: the byte at the lowest address becomes the least significant byte of the result. When the last cycle completes, the requester sees a one-clock completion pulse. While a request is in flight the block reports itself busy and takes no new request.

The lane width is fixed at eight bits. The address width and the bus width are parameters, and the number of lanes must be a power of two.

Top module: `bytelane_cycle_splitter`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy`, `done` and `bus_cyc` are low, all bits of `bus_be_n` are high and `bus_wdata` is zero. Whenever `bus_cyc` is low, `bus_be_n` is all ones.
- R2: The size code selects the byte count: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes, and the reserved code 3 means the full bus width (4 bytes on a 32-bit bus). Lane k carries bits 8k+7:8k and serves the byte whose address, taken modulo the lane count, is k. A bus cycle drives `bus_be_n[k]` low exactly for the lanes of the requested bytes that fall in that cycle's word, and this group is always contiguous and never empty.
- R3: The first bus cycle of a request drives `bus_addr` equal to the request address with its two lowest bits removed.
- R4: When the low address bits plus the byte count exceed the lane count, a second bus cycle follows. Its `bus_addr` is the first address plus one, wrapping to zero at the top of the address range, and it enables lanes 0 upward for the remaining bytes.
- R5: On a write, request byte i, at bits 8i+7:8i, appears on lane (address + i) modulo the lane count. All lanes whose enable is high carry zero. On a read, `bus_wdata` is zero.
- R6: On a read, the completion result in `rd_data` holds the bytes of the enabled lanes in address order, lowest address in bits 7:0, and it is zero above the requested byte count. After a write, `rd_data` is zero.
- R7: A bus cycle keeps `bus_addr`, `bus_be_n` and `bus_wdata` unchanged until `bus_ready` is sampled high. `bus_rdata` is taken only on the clock edge where `bus_ready` is high. While no cycle is active, `bus_ready` has no effect.
- R8: After `bus_ready` is sampled high in the final bus cycle, `done` is high for exactly one clock in the next cycle, and `bus_cyc` is low in that cycle.
- R9: A request is taken only when `busy` is low. `busy` is high from the clock after acceptance through the clock in which `done` is high. Requests presented while `busy` is high are ignored.
- R10: The second cycle of a split request begins in the clock right after the first cycle's ready, with no idle clock between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe; taken while idle |
| req_addr | input | ADDR_W | Byte address of the first byte |
| req_size | input | 2 | Size code (0: 1 byte, 1: 2 bytes, 2: 4 bytes, 3: full width) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | DATA_W | Write bytes, right-justified |
| busy | output | 1 | Request in flight |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | DATA_W | Right-justified read result, valid with `done` |
| bus_cyc | output | 1 | A bus cycle is active |
| bus_addr | output | ADDR_W-2 | Aligned word address |
| bus_be_n | output | DATA_W/8 | Active-low byte enables |
| bus_wdata | output | DATA_W | Lane-aligned write data |
| bus_rdata | input | DATA_W | Lane data returned by the bus |
| bus_ready | input | 1 | Completes the current bus cycle |

## Verification
The bench builds the block with a 16-bit address and the default 32-bit bus. With the narrow address, a two-byte or four-byte request near address 0xFFFF reaches the wrap of the second-cycle word address back to zero within a short run. The 32-bit bus gives all sixteen pairs of offset and size, including the three-lane partial transfers of a split. The reserved size code then resolves to four bytes, and every lane group is compared against a byte-by-byte model at each clock.

// File: rtl/bls_pkg.sv
package bls_pkg;

    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_FIN    = 2'd3
    } bls_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } bls_size_e;

    // Byte count of a size code, clamped to the number of lanes
    function automatic int size_to_bytes(input logic [1:0] code, input int lanes);
        int n;
        n = 1 << code;
        if (n > lanes) begin
            n = lanes;
        end
        return n;
    endfunction

endpackage

// File: rtl/bls_lane_plan.sv
module bls_lane_plan
    import bls_pkg::*;
#(
    parameter int LANES = 4,
    parameter int OFF_W = 2
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [1:0]       size_code,
    output logic [LANES-1:0] first_mask,
    output logic [LANES-1:0] second_mask,
    output logic             split
);
    localparam int SPAN = 2 * LANES;

    logic [SPAN-1:0] base;
    logic [SPAN-1:0] placed;
    int              nbytes;

    always_comb begin
        nbytes = size_to_bytes(size_code, LANES);
        base   = '0;
        for (int i = 0; i < LANES; i++) begin
            if (i < nbytes) begin
                base[i] = 1'b1;
            end
        end
        placed = base << offset;
    end

    assign first_mask  = placed[LANES-1:0];
    assign second_mask = placed[SPAN-1:LANES];
    assign split       = |second_mask;

endmodule

// File: rtl/bls_lane_rotate.sv
module bls_lane_rotate
    import bls_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int OFF_W    = 2,
    parameter bit ROT_LEFT = 1'b1
) (
    input  logic [OFF_W-1:0]        offset,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout
);
    logic [OFF_W-1:0] src;

    if (ROT_LEFT) begin : g_left
        // output lane l takes input byte (l - offset)
        always_comb begin
            dout = '0;
            src  = '0;
            for (int l = 0; l < LANES; l++) begin
                src = OFF_W'(l) - offset;
                dout[l*LANE_W +: LANE_W] = din[src*LANE_W +: LANE_W];
            end
        end
    end else begin : g_right
        // output byte l takes input lane (l + offset)
        always_comb begin
            dout = '0;
            src  = '0;
            for (int l = 0; l < LANES; l++) begin
                src = OFF_W'(l) + offset;
                dout[l*LANE_W +: LANE_W] = din[src*LANE_W +: LANE_W];
            end
        end
    end

endmodule

// File: rtl/bls_read_gather.sv
module bls_read_gather
    import bls_pkg::*;
#(
    parameter int LANES = 4,
    parameter int OFF_W = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    capture,
    input  logic [OFF_W-1:0]        offset,
    input  logic [LANES-1:0]        lane_mask,
    input  logic [LANES*LANE_W-1:0] lane_data,
    output logic [LANES*LANE_W-1:0] result
);
    localparam int DW = LANES * LANE_W;

    logic [DW-1:0] kept;
    logic [DW-1:0] justified;
    logic [DW-1:0] acc_q;

    always_comb begin
        kept = '0;
        for (int l = 0; l < LANES; l++) begin
            kept[l*LANE_W +: LANE_W] = lane_data[l*LANE_W +: LANE_W] & {LANE_W{lane_mask[l]}};
        end
    end

    bls_lane_rotate #(
        .LANES   (LANES),
        .OFF_W   (OFF_W),
        .ROT_LEFT(1'b0)
    ) u_rot_rd (
        .offset(offset),
        .din   (kept),
        .dout  (justified)
    );

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
        end else if (capture) begin
            acc_q <= acc_q | justified;
        end
    end

    assign result = acc_q;

    AST_GATHER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clear |=> (acc_q == '0)); // R6

endmodule

// File: rtl/bytelane_cycle_splitter.sv
module bytelane_cycle_splitter
    import bls_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [1:0]                 req_size,
    input  logic                       req_write,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic                       busy,
    output logic                       done,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       bus_cyc,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0] bus_addr,
    output logic [DATA_W/8-1:0]        bus_be_n,
    output logic [DATA_W-1:0]          bus_wdata,
    input  logic [DATA_W-1:0]          bus_rdata,
    input  logic                       bus_ready
);
    localparam int LANES = DATA_W / LANE_W;
    localparam int OFF_W = $clog2(LANES);
    localparam int DW_W  = ADDR_W - OFF_W;

    typedef struct packed {
        logic [DW_W-1:0]   dw;
        logic [OFF_W-1:0]  off;
        logic [LANES-1:0]  tail_mask;
        logic              split;
        logic              write;
        logic [DATA_W-1:0] lane_data;
    } hold_t;

    typedef struct packed {
        logic [DW_W-1:0]   addr;
        logic [LANES-1:0]  be_n;
        logic [DATA_W-1:0] wdata;
    } beat_t;

    function automatic logic [DATA_W-1:0] lanes_to_bits(input logic [LANES-1:0] m);
        logic [DATA_W-1:0] r;
        for (int l = 0; l < LANES; l++) begin
            r[l*LANE_W +: LANE_W] = {LANE_W{m[l]}};
        end
        return r;
    endfunction

    function automatic beat_t make_beat(input logic [DW_W-1:0] a, input logic [LANES-1:0] m,
                                        input logic wr, input logic [DATA_W-1:0] d);
        beat_t b;
        b.addr  = a;
        b.be_n  = ~m;
        b.wdata = wr ? (d & lanes_to_bits(m)) : '0;
        return b;
    endfunction

    localparam beat_t IDLE_BEAT = '{addr: '0, be_n: '1, wdata: '0};

    bls_state_e        state_q;
    hold_t             hold_q;
    beat_t             beat_q;

    logic [OFF_W-1:0]  req_off;
    logic [LANES-1:0]  m_first;
    logic [LANES-1:0]  m_second;
    logic              m_split;
    logic [DATA_W-1:0] wdata_rot;
    logic              accept;
    logic              beat_end;
    logic [DW_W-1:0]   next_dw;

    assign req_off = req_addr[OFF_W-1:0];

    bls_lane_plan #(
        .LANES(LANES),
        .OFF_W(OFF_W)
    ) u_plan (
        .offset     (req_off),
        .size_code  (req_size),
        .first_mask (m_first),
        .second_mask(m_second),
        .split      (m_split)
    );

    bls_lane_rotate #(
        .LANES   (LANES),
        .OFF_W   (OFF_W),
        .ROT_LEFT(1'b1)
    ) u_rot_wr (
        .offset(req_off),
        .din   (req_wdata),
        .dout  (wdata_rot)
    );

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign beat_end = bus_cyc && bus_ready;
    assign next_dw  = hold_q.dw + DW_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
            beat_q  <= IDLE_BEAT;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q          <= ST_FIRST;
                        hold_q.dw        <= req_addr[ADDR_W-1:OFF_W];
                        hold_q.off       <= req_off;
                        hold_q.tail_mask <= m_second;
                        hold_q.split     <= m_split;
                        hold_q.write     <= req_write;
                        hold_q.lane_data <= wdata_rot;
                        beat_q           <= make_beat(req_addr[ADDR_W-1:OFF_W], m_first,
                                                      req_write, wdata_rot);
                    end
                end
                ST_FIRST: begin
                    if (bus_ready) begin
                        if (hold_q.split) begin
                            state_q <= ST_SECOND;
                            beat_q  <= make_beat(next_dw, hold_q.tail_mask,
                                                 hold_q.write, hold_q.lane_data);
                        end else begin
                            state_q <= ST_FIN;
                            beat_q  <= IDLE_BEAT;
                        end
                    end
                end
                ST_SECOND: begin
                    if (bus_ready) begin
                        state_q <= ST_FIN;
                        beat_q  <= IDLE_BEAT;
                    end
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    bls_read_gather #(
        .LANES(LANES),
        .OFF_W(OFF_W)
    ) u_gather (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .capture  (beat_end && !hold_q.write),
        .offset   (hold_q.off),
        .lane_mask(~beat_q.be_n),
        .lane_data(bus_rdata),
        .result   (rd_data)
    );

    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_FIN);
    assign bus_cyc   = (state_q == ST_FIRST) || (state_q == ST_SECOND);
    assign bus_addr  = beat_q.addr;
    assign bus_be_n  = beat_q.be_n;
    assign bus_wdata = beat_q.wdata;

    AST_IDLE_NO_LANES: assert property (@(posedge clk) disable iff (rst)
        !bus_cyc |-> (bus_be_n == '1)); // R1

    AST_LANES_CONTIG: assert property (@(posedge clk) disable iff (rst)
        bus_cyc |-> ($countones({1'b0, ~bus_be_n} ^ {~bus_be_n, 1'b0}) == 2)); // R2

    AST_SECOND_ADDR: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_cyc && bus_ready) && bus_cyc) |-> (bus_addr == $past(bus_addr) + DW_W'(1))); // R4

    AST_DEAD_LANES_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_cyc |-> ((bus_wdata & ~lanes_to_bits(~bus_be_n)) == '0)); // R5

    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && !bus_ready) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_be_n)
                                     && $stable(bus_wdata))); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(bus_cyc && bus_ready)); // R8

    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy && !bus_cyc)); // R9

endmodule

// File: tb/bytelane_cycle_splitter_tb.sv
`timescale 1ns/1ps
module bytelane_cycle_splitter_tb_top;

    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic [1:0]    req_size;
    logic          req_write;
    logic [DW-1:0] req_wdata;
    logic          busy;
    logic          done;
    logic [DW-1:0] rd_data;
    logic          bus_cyc;
    logic [AW-3:0] bus_addr;
    logic [3:0]    bus_be_n;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic          bus_ready;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bytelane_cycle_splitter #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .bus_cyc(bus_cyc),
        .bus_addr(bus_addr), .bus_be_n(bus_be_n), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    function automatic logic [31:0] mem_word(input logic [AW-3:0] dw);
        return (32'(dw) * 32'h9E37_79B1) ^ 32'h5A3C_0F96;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] got,
                       input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic run_txn(input logic [AW-1:0] a, input logic [1:0] sz, input logic wr,
                           input logic [31:0] wd, input int w1, input int w2,
                           input bit hold_req);
        int            n;
        logic [AW-1:0] ai;
        logic [AW-3:0] dwa [2];
        logic [3:0]    be  [2];
        logic [31:0]   wl  [2];
        logic [31:0]   rexp;
        int            nph;
        n      = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        dwa[0] = a[AW-1:2];
        dwa[1] = dwa[0] + 1'b1;
        be[0]  = 4'hF; be[1] = 4'hF;
        wl[0]  = '0;   wl[1] = '0;
        rexp   = '0;
        for (int i = 0; i < n; i++) begin
            int ph;
            int ln;
            ai = a + AW'(i);
            ln = int'(ai[1:0]);
            ph = (ai[AW-1:2] == dwa[0]) ? 0 : 1;
            be[ph][ln] = 1'b0;
            if (wr) wl[ph][ln*8 +: 8] = wd[i*8 +: 8];
            else    rexp[i*8 +: 8]    = mem_word(dwa[ph])[ln*8 +: 8];
        end
        nph = (be[1] != 4'hF) ? 2 : 1;

        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
        @(posedge clk); @(negedge clk);
        if (hold_req) begin
            req_addr  = a ^ 16'h1235;
            req_size  = 2'd2;
            req_write = ~wr;
            req_wdata = ~wd;
        end else begin
            req_valid = 1'b0;
        end
        for (int p = 0; p < nph; p++) begin
            int wt;
            wt = (p == 0) ? w1 : w2;
            for (int w = 0; w <= wt; w++) begin
                string rq;
                rq = (p == 0) ? "R3" : "R4";
                chk((p == 0) ? "R9" : "R10", "bus_cyc", 64'(bus_cyc), 64'd1);
                chk("R9", "busy", 64'(busy), 64'd1);
                chk("R8", "done mid", 64'(done), 64'd0);
                chk(rq, "bus_addr", 64'(bus_addr), 64'(dwa[p]));
                chk("R2", "bus_be_n", 64'(bus_be_n), 64'(be[p]));
                chk("R5", "bus_wdata", 64'(bus_wdata), 64'(wl[p]));
                if (w > 0) chk("R7", "hold addr", 64'(bus_addr), 64'(dwa[p]));
                bus_ready = (w == wt);
                bus_rdata = (w == wt) ? mem_word(dwa[p]) : 32'hDEAD_BEEF;
                @(posedge clk); @(negedge clk);
            end
        end
        bus_ready = 1'b0;
        req_valid = 1'b0;
        chk("R8", "done", 64'(done), 64'd1);
        chk("R9", "busy at done", 64'(busy), 64'd1);
        chk("R8", "bus_cyc at done", 64'(bus_cyc), 64'd0);
        chk("R1", "be_n at done", 64'(bus_be_n), 64'hF);
        chk("R6", "rd_data", 64'(rd_data), 64'(rexp));
        @(posedge clk); @(negedge clk);
        chk("R8", "done pulse", 64'(done), 64'd0);
        chk("R9", "busy after", 64'(busy), 64'd0);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_size = '0; req_write = 1'b0;
        req_wdata = '0; bus_rdata = '0; bus_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "busy in reset", 64'(busy), 64'd0);
        chk("R1", "be_n in reset", 64'(bus_be_n), 64'hF);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1", "done after reset", 64'(done), 64'd0);
        chk("R1", "bus_cyc after reset", 64'(bus_cyc), 64'd0);
        chk("R1", "wdata after reset", 64'(bus_wdata), 64'd0);

        // R7: ready while idle does nothing
        bus_ready = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); @(negedge clk);
            chk("R7", "idle ready bus_cyc", 64'(bus_cyc), 64'd0);
            chk("R7", "idle ready done", 64'(done), 64'd0);
        end
        bus_ready = 1'b0;

        // every offset and size, both directions
        for (int wr = 0; wr < 2; wr++) begin
            for (int off = 0; off < 4; off++) begin
                for (int sz = 0; sz < 4; sz++) begin
                    run_txn(AW'(16'h1230 + off), 2'(sz), wr[0], 32'hA1B2_C3D4, sz % 2, off % 3, 1'b0);
                end
            end
        end
        // R4: wrap of the word address at the top of the range
        run_txn(16'hFFFF, 2'd1, 1'b0, 32'h0, 0, 1, 1'b0);
        run_txn(16'hFFFE, 2'd2, 1'b1, 32'h1122_3344, 1, 0, 1'b0);
        run_txn(16'hFFFD, 2'd3, 1'b0, 32'h0, 0, 0, 1'b0);
        // R9: requests held during busy are ignored
        run_txn(16'h0043, 2'd2, 1'b1, 32'hCAFE_F00D, 2, 2, 1'b1);
        run_txn(16'h0082, 2'd1, 1'b0, 32'h0, 1, 0, 1'b1);
        // random mix
        for (int k = 0; k < 250; k++) begin
            run_txn(AW'($urandom), 2'($urandom), 1'($urandom), $urandom,
                    int'($urandom % 3), int'($urandom % 3), 1'($urandom));
        end
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL R8 watchdog: actual no completion expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule